// File: doc/BRIEF.md
# Stacked-Carrier Fifteen-Level PWM Generator

This block produces the switching commands for a fifteen-level cascaded inverter. An internal phase accumulator produces a sinusoidal reference. The reference is scaled by a modulation index and then rectified. Seven carriers are stacked above one another, and each spans one unit of amplitude. The rectified reference is compared against every carrier. The number of carriers it exceeds is the magnitude level, from 0 to 7. The sign of the reference drives one of two polarity pairs: one pair for the positive half cycle and one for the negative half cycle.

The carrier arrangement is set by a 3-bit mode code, with three families:

- In-phase triangles.
- Triangles whose adjacent bands are in phase opposition.
- Inverted half-sine shapes.

Each family has a fixed-frequency variant and a variable-frequency variant. In the variable-frequency variant the middle three bands run at twice the rate of the outer four.

A small state machine accepts a new mode code and holds it until the reference crosses zero. Its states are `ST_LOCKED` and `ST_PENDING`, with these transitions:

- `ST_LOCKED` to `ST_PENDING`: a legal code differs from the active mode.
- `ST_PENDING` to `ST_LOCKED` (commit): a zero crossing occurs, and the requested mode becomes active.
- `ST_PENDING` to `ST_LOCKED` (cancel): the code returns to the active mode.

Time advances on a carrier tick that comes every `TICK_DIV` clocks. A slow carrier cycle lasts `SLOW_PERIOD` ticks and a fast cycle lasts half of that.

Top module: `mlpwm_gen`

## Requirements
- R1: `cmp_bits[k]` is 1 when the rectified reference exceeds carrier band k. `cmp_bits` is always a thermometer code with ones from bit 0 upward. `level` equals the number of ones in `cmp_bits`.
- R2: Band k covers magnitudes k*256 to k*256+255. The rectified reference equals s*m*7/2048, where s is the sine magnitude (at most 2046) and m is `mod_index`. The peak level over a reference cycle is 0 for m=0, 4 for m=128 and 7 for m=255.
- R3: In fixed-frequency modes every band completes one carrier cycle per `SLOW_PERIOD` ticks (500 by default).
- R4: In opposition modes the odd bands carry triangles that are inverted relative to the phase-disposition triangle. With the reference held constant, the switching instants of band 3 move by half a carrier period.
- R5: In inverted-sine modes every carrier has an inverted half-sine shape, which is low in mid-period and high at the period ends. With the reference held at the middle of a band, the band's comparison bit is high for roughly 70% of each cycle.
- R6: In variable-frequency modes bands 2, 3 and 4 complete a cycle every `SLOW_PERIOD`/2 ticks, and bands 0, 1, 5 and 6 complete a cycle every `SLOW_PERIOD` ticks.
- R7: Both bits of `gate_pos` are 1 while the reference is positive and `level` is nonzero. Both bits of `gate_neg` are 1 while the reference is negative and `level` is nonzero. The two pairs are never active together.
- R8: When `level` is 0, all four polarity gates are 0.
- R9: A changed mode code takes effect only at the next zero crossing of the reference. Codes 6 and 7 are ignored.
- R10: All outputs are registered. While reset is low every output is 0, and after reset the reference starts at phase zero with the phase-disposition mode active.
- R11: The mode codes are: 0 = in-phase triangles, 1 = opposition triangles, 2 = inverted sine, 3 = variable-frequency in-phase, 4 = variable-frequency opposition, 5 = variable-frequency inverted sine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 3 | Requested carrier arrangement code |
| mod_index | input | MI_W | Modulation index; all ones is full scale |
| phase_inc | input | PH_W | Reference phase step per carrier tick |
| cmp_bits | output | 7 | Per-band comparison results |
| level | output | 3 | Magnitude level, 0 to 7 |
| gate_pos | output | 2 | Positive half-cycle polarity pair |
| gate_neg | output | 2 | Negative half-cycle polarity pair |

## Verification
The embedded properties check several rules on every clock cycle:

- The comparison bits form a thermometer code, and the level equals their count.
- The polarity pairs stay exclusive and move together, and they are silent at level zero.
- The two carrier counters stay aligned.
- The active mode is always a legal code and changes only in the cycle after a zero crossing.

Carrier frequency per band, the half-period shift of opposition carriers, the duty cycle produced by the inverted-sine shape, the peak level for a given modulation index, and the deferral of mode changes cannot be seen cycle by cycle. These are shown only by the bench's scenarios, which hold the reference constant and measure edges and duty over many carrier periods.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    typedef enum logic [2:0] {
        MODE_PD      = 3'd0,
        MODE_APOD    = 3'd1,
        MODE_ISIN    = 3'd2,
        MODE_VF_PD   = 3'd3,
        MODE_VF_APOD = 3'd4,
        MODE_VF_ISIN = 3'd5
    } carrier_mode_e;

    localparam int BANDS   = 7;
    localparam int CAR_W   = 8;
    localparam int MAG_W   = CAR_W + 3;
    localparam int SIN_W   = 11;
    localparam int PHS_W   = CAR_W + 1;
    localparam int MID_LO  = (BANDS - 3) / 2;
    localparam int MID_HI  = MID_LO + 2;
    localparam int QW_N    = 64;
    localparam int QW_IW   = $clog2(QW_N);
    localparam int QW_AMP  = (1 << SIN_W) - 1;

    // Quarter-wave sine approximation: q*(2-q) on q = i/N, scaled to QW_AMP.
    function automatic logic [SIN_W-1:0] qsine(input int i);
        int v;
        v = (i * (2 * QW_N - i) * QW_AMP) / (QW_N * QW_N);
        return SIN_W'(v);
    endfunction

    // Fold a half-wave position into a quarter-wave table index.
    function automatic logic [QW_IW-1:0] quarter_idx(input logic [CAR_W-1:0] pos);
        return pos[CAR_W-1] ? ~pos[CAR_W-2:1] : pos[CAR_W-2:1];
    endfunction

    function automatic logic mode_legal(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic mode_is_vf(input carrier_mode_e m);
        return (m == MODE_VF_PD) || (m == MODE_VF_APOD) || (m == MODE_VF_ISIN);
    endfunction

    function automatic logic mode_is_apod(input carrier_mode_e m);
        return (m == MODE_APOD) || (m == MODE_VF_APOD);
    endfunction

    function automatic logic mode_is_isin(input carrier_mode_e m);
        return (m == MODE_ISIN) || (m == MODE_VF_ISIN);
    endfunction

endpackage

// File: rtl/mlpwm_qrom.sv
module mlpwm_qrom
    import mlpwm_pkg::*;
(
    input  logic [QW_IW-1:0] idx,
    output logic [SIN_W-1:0] val
);

    logic [SIN_W-1:0] table_w [QW_N];

    for (genvar g = 0; g < QW_N; g++) begin : g_entry
        assign table_w[g] = qsine(g);
    end

    assign val = table_w[idx];

endmodule

// File: rtl/mlpwm_timebase.sv
module mlpwm_timebase
    import mlpwm_pkg::*;
#(
    parameter int TICK_DIV    = 50,
    parameter int SLOW_PERIOD = 500,
    parameter int PH_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  phase_inc,
    output logic [PHS_W-1:0] ph_slow,
    output logic [PHS_W-1:0] ph_fast,
    output logic [PH_W-1:0]  ref_acc
);

    localparam int FAST_PERIOD = SLOW_PERIOD / 2;
    localparam int DIV_W       = $clog2(TICK_DIV + 1);
    localparam int CNT_W       = $clog2(SLOW_PERIOD + 1);
    localparam int SPAN        = 1 << PHS_W;

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] slow_q;
    logic [CNT_W-1:0] fast_q;
    logic             tick;

    assign tick = (div_q == DIV_W'(TICK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            slow_q  <= '0;
            fast_q  <= '0;
            ref_acc <= '0;
        end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                slow_q  <= (slow_q == CNT_W'(SLOW_PERIOD - 1)) ? '0 : slow_q + 1'b1;
                fast_q  <= (fast_q == CNT_W'(FAST_PERIOD - 1)) ? '0 : fast_q + 1'b1;
                ref_acc <= ref_acc + phase_inc;
            end
        end
    end

    // Scale each counter onto a common 0..SPAN-1 phase.
    always_comb begin
        ph_slow = PHS_W'((32'(slow_q) * SPAN) / SLOW_PERIOD);
        ph_fast = PHS_W'((32'(fast_q) * SPAN) / FAST_PERIOD);
    end

    a_r6_fast_range: assert property (@(posedge clk) disable iff (!rst_n)
        fast_q < CNT_W'(FAST_PERIOD));
    a_r6_aligned_start: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_q == '0) |-> (fast_q == '0));
    a_r6_aligned_half: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_q == CNT_W'(FAST_PERIOD)) |-> (fast_q == '0));

endmodule

// File: rtl/mlpwm_reference.sv
module mlpwm_reference
    import mlpwm_pkg::*;
#(
    parameter int PH_W = 16,
    parameter int MI_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  ref_acc,
    input  logic [MI_W-1:0]  mod_index,
    output logic [MAG_W-1:0] mag,
    output logic             neg,
    output logic             zc
);

    localparam int PROD_W = SIN_W + MI_W + 3;

    logic [CAR_W-1:0]  pos;
    logic [SIN_W-1:0]  sine_mag;
    logic [PROD_W-1:0] prod;
    logic              sign_q;
    logic              unused_bits;

    assign pos = ref_acc[PH_W-2 -: CAR_W];

    mlpwm_qrom u_rom (
        .idx (quarter_idx(pos)),
        .val (sine_mag)
    );

    assign prod        = PROD_W'(sine_mag) * PROD_W'(mod_index) * PROD_W'(7);
    assign mag         = prod[PROD_W-1 -: MAG_W];
    assign neg         = ref_acc[PH_W-1];
    assign unused_bits = ^{prod[PROD_W-MAG_W-1:0], ref_acc[PH_W-CAR_W-2:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sign_q <= 1'b0;
        else        sign_q <= neg;
    end

    assign zc = neg ^ sign_q;

    a_r2_mag_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mag < MAG_W'(BANDS << CAR_W));

endmodule

// File: rtl/mlpwm_carriers.sv
module mlpwm_carriers
    import mlpwm_pkg::*;
(
    input  carrier_mode_e                 mode,
    input  logic [PHS_W-1:0]              ph_slow,
    input  logic [PHS_W-1:0]              ph_fast,
    output logic [BANDS-1:0][CAR_W-1:0]   car
);

    logic [SIN_W-1:0] sin_slow;
    logic [SIN_W-1:0] sin_fast;
    logic [CAR_W-1:0] is_slow;
    logic [CAR_W-1:0] is_fast;
    logic [CAR_W-1:0] tri_slow;
    logic [CAR_W-1:0] tri_fast;
    logic             unused_low;

    mlpwm_qrom u_rom_slow (
        .idx (quarter_idx(ph_slow[PHS_W-1:1])),
        .val (sin_slow)
    );

    mlpwm_qrom u_rom_fast (
        .idx (quarter_idx(ph_fast[PHS_W-1:1])),
        .val (sin_fast)
    );

    // Inverted half-sine: full at the period ends, zero in mid-period.
    assign is_slow    = ~sin_slow[SIN_W-1 -: CAR_W];
    assign is_fast    = ~sin_fast[SIN_W-1 -: CAR_W];
    assign unused_low = ^{sin_slow[SIN_W-CAR_W-1:0], sin_fast[SIN_W-CAR_W-1:0]};

    assign tri_slow = ph_slow[PHS_W-1] ? ~ph_slow[CAR_W-1:0] : ph_slow[CAR_W-1:0];
    assign tri_fast = ph_fast[PHS_W-1] ? ~ph_fast[CAR_W-1:0] : ph_fast[CAR_W-1:0];

    for (genvar k = 0; k < BANDS; k++) begin : g_band
        localparam bit MIDDLE = (k >= MID_LO) && (k <= MID_HI);
        localparam bit ODD    = (k % 2) == 1;
        logic fast_sel;
        always_comb begin
            fast_sel = MIDDLE && mode_is_vf(mode);
            if (mode_is_isin(mode)) begin
                car[k] = fast_sel ? is_fast : is_slow;
            end else begin
                car[k] = fast_sel ? tri_fast : tri_slow;
                if (mode_is_apod(mode) && ODD) car[k] = ~car[k];
            end
        end
    end

endmodule

// File: rtl/mlpwm_mode_fsm.sv
module mlpwm_mode_fsm
    import mlpwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_sel,
    input  logic          zc,
    output carrier_mode_e mode_act
);

    typedef enum logic {
        ST_LOCKED,
        ST_PENDING
    } fsm_state_e;

    fsm_state_e    state_q, state_d;
    carrier_mode_e req_q, req_d;
    carrier_mode_e act_d;
    logic          sel_ok;
    carrier_mode_e sel_m;

    assign sel_ok = mode_legal(mode_sel);
    assign sel_m  = carrier_mode_e'(mode_sel);

    always_comb begin
        state_d = state_q;
        req_d   = req_q;
        act_d   = mode_act;
        unique case (state_q)
            ST_LOCKED: begin
                if (sel_ok && (sel_m != mode_act)) begin
                    state_d = ST_PENDING;
                    req_d   = sel_m;
                end
            end
            ST_PENDING: begin
                if (sel_ok) req_d = sel_m;
                if (zc) begin
                    act_d   = sel_ok ? sel_m : req_q;
                    state_d = ST_LOCKED;
                end else if (sel_ok && (sel_m == mode_act)) begin
                    state_d = ST_LOCKED;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_LOCKED;
            req_q    <= MODE_PD;
            mode_act <= MODE_PD;
        end else begin
            state_q  <= state_d;
            req_q    <= req_d;
            mode_act <= act_d;
        end
    end

    a_r9_switch_on_crossing: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act != $past(mode_act)) |-> $past(zc));
    a_r9_legal_active: assert property (@(posedge clk) disable iff (!rst_n)
        mode_legal(mode_act));
    a_r9_pending_differs: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PENDING) |-> (req_q != mode_act));

endmodule

// File: rtl/mlpwm_gen.sv
module mlpwm_gen
    import mlpwm_pkg::*;
#(
    parameter int TICK_DIV    = 50,
    parameter int SLOW_PERIOD = 500,
    parameter int PH_W        = 16,
    parameter int MI_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic [MI_W-1:0]   mod_index,
    input  logic [PH_W-1:0]   phase_inc,
    output logic [BANDS-1:0]  cmp_bits,
    output logic [2:0]        level,
    output logic [1:0]        gate_pos,
    output logic [1:0]        gate_neg
);

    localparam int LVL_W = $clog2(BANDS + 1);

    logic [PHS_W-1:0]            ph_slow;
    logic [PHS_W-1:0]            ph_fast;
    logic [PH_W-1:0]             ref_acc;
    logic [MAG_W-1:0]            mag;
    logic                        neg;
    logic                        zc;
    carrier_mode_e               mode_act;
    logic [BANDS-1:0][CAR_W-1:0] car;
    logic [BANDS-1:0]            cmp_d;
    logic [LVL_W-1:0]            level_d;
    logic                        drive_pos;
    logic                        drive_neg;

    mlpwm_timebase #(
        .TICK_DIV    (TICK_DIV),
        .SLOW_PERIOD (SLOW_PERIOD),
        .PH_W        (PH_W)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_inc (phase_inc),
        .ph_slow   (ph_slow),
        .ph_fast   (ph_fast),
        .ref_acc   (ref_acc)
    );

    mlpwm_reference #(
        .PH_W (PH_W),
        .MI_W (MI_W)
    ) u_reference (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_acc   (ref_acc),
        .mod_index (mod_index),
        .mag       (mag),
        .neg       (neg),
        .zc        (zc)
    );

    mlpwm_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .zc       (zc),
        .mode_act (mode_act)
    );

    mlpwm_carriers u_carriers (
        .mode    (mode_act),
        .ph_slow (ph_slow),
        .ph_fast (ph_fast),
        .car     (car)
    );

    // Each carrier is lifted by its band number in whole units.
    for (genvar k = 0; k < BANDS; k++) begin : g_cmp
        assign cmp_d[k] = mag > {3'(k), car[k]};
    end

    always_comb begin
        level_d = '0;
        for (int k = 0; k < BANDS; k++) level_d = level_d + LVL_W'(cmp_d[k]);
    end

    assign drive_pos = !neg && (level_d != '0);
    assign drive_neg =  neg && (level_d != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_bits <= '0;
            level    <= '0;
            gate_pos <= '0;
            gate_neg <= '0;
        end else begin
            cmp_bits <= cmp_d;
            level    <= 3'(level_d);
            gate_pos <= {2{drive_pos}};
            gate_neg <= {2{drive_neg}};
        end
    end

    for (genvar k = 0; k < BANDS - 1; k++) begin : g_thermo_chk
        a_r1_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_bits[k+1] |-> cmp_bits[k]);
    end

    a_r1_level_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmp_bits) == int'(level));
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !((gate_pos != 2'b00) && (gate_neg != 2'b00)));
    a_r7_pairs_move_together: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_pos[0] == gate_pos[1]) && (gate_neg[0] == gate_neg[1]));
    a_r8_idle_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 3'd0) |-> ((gate_pos == 2'b00) && (gate_neg == 2'b00)));

endmodule

// File: tb/mlpwm_gen_test.sv
module mlpwm_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 2;
    localparam int SLOW_CLKS  = 500 * TDIV;

    logic       clk;
    logic       rst_n;
    logic [2:0] mode_sel;
    logic [7:0] mod_index;
    logic [15:0] phase_inc;
    logic [6:0] cmp_bits;
    logic [2:0] level;
    logic [1:0] gate_pos;
    logic [1:0] gate_neg;

    int     checks;
    int     errors;
    longint cyc;
    longint base;
    bit     done;

    mlpwm_gen #(
        .TICK_DIV    (TDIV),
        .SLOW_PERIOD (500),
        .PH_W        (16),
        .MI_W        (8)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .mod_index (mod_index),
        .phase_inc (phase_inc),
        .cmp_bits  (cmp_bits),
        .level     (level),
        .gate_pos  (gate_pos),
        .gate_neg  (gate_neg)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    initial cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit is_thermo(input logic [6:0] b);
        return ((b + 7'd1) & b) == 7'd0;
    endfunction

    task automatic start(input int mode, input int m, input int inc);
        @(negedge clk);
        rst_n     = 1'b0;
        mode_sel  = 3'(mode);
        mod_index = 8'(m);
        phase_inc = 16'(inc);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        base  = cyc;
    endtask

    // Run until the reference sits near its positive peak, then stop it.
    task automatic freeze_at_peak(input int mode, input int m);
        start(mode, m, 32);
        repeat (5120) @(negedge clk);
        phase_inc = 16'd0;
        repeat (8) @(negedge clk);
    endtask

    task automatic watch_band(input int bitn, input int nclk,
                              output int rises, output int highs, output longint first);
        logic prev;
        rises = 0;
        highs = 0;
        first = -1;
        prev  = cmp_bits[bitn];
        for (int i = 0; i < nclk; i++) begin
            @(negedge clk);
            if (cmp_bits[bitn]) highs++;
            if (cmp_bits[bitn] && !prev) begin
                rises++;
                if (first < 0) first = cyc - base;
            end
            prev = cmp_bits[bitn];
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n     = 1'b0;
        mode_sel  = 3'd1;
        mod_index = 8'd255;
        phase_inc = 16'd0;
        repeat (3) @(negedge clk);
        check({cmp_bits, level, gate_pos, gate_neg} == 14'd0, "R10 outputs zero in reset",
              {cmp_bits, level, gate_pos, gate_neg}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check((level == 3'd0) && (gate_pos == 2'b00) && (gate_neg == 2'b00),
              "R10 phase zero after reset gives level 0 and idle gates (R8)", level, 0);
    endtask

    task automatic t_sweep(input int m, input int exp_max);
        int  maxl = 0;
        int  thermo_bad = 0, count_bad = 0, pol_bad = 0, idle_bad = 0;
        bit  seen_pos = 0, seen_neg = 0;
        start(0, m, 32);
        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            if (int'(level) > maxl) maxl = int'(level);
            if (!is_thermo(cmp_bits)) thermo_bad++;
            if ($countones(cmp_bits) != int'(level)) count_bad++;
            if ((level == 3'd0) && ((gate_pos != 2'b00) || (gate_neg != 2'b00))) idle_bad++;
            if (i >= 60 && i <= 1990) begin
                if (gate_neg != 2'b00) pol_bad++;
                if ((level != 3'd0) && (gate_pos != 2'b11)) pol_bad++;
                if (gate_pos == 2'b11) seen_pos = 1;
            end
            if (i >= 2110 && i <= 4040) begin
                if (gate_pos != 2'b00) pol_bad++;
                if ((level != 3'd0) && (gate_neg != 2'b11)) pol_bad++;
                if (gate_neg == 2'b11) seen_neg = 1;
            end
        end
        check(thermo_bad == 0, "R1 thermometer comparison bits", thermo_bad, 0);
        check(count_bad == 0, "R1 level equals count of set bits", count_bad, 0);
        check(maxl == exp_max, "R2 peak level for modulation index", maxl, exp_max);
        check(idle_bad == 0, "R8 gates idle at level 0", idle_bad, 0);
        check(pol_bad == 0, "R7 polarity pair follows half cycle", pol_bad, 0);
        if (exp_max > 0)
            check(seen_pos && seen_neg, "R7 both polarity pairs used over a cycle",
                  {seen_pos, seen_neg}, 3);
    endtask

    task automatic t_rate(input int mode, input int m, input int bitn,
                          input int lo, input int hi, input string req);
        int rises, highs;
        longint first;
        freeze_at_peak(mode, m);
        watch_band(bitn, 5000, rises, highs, first);
        check(rises >= lo && rises <= hi, req, rises, (lo + hi) / 2);
    endtask

    task automatic t_shape;
        int rises, highs;
        longint first;
        freeze_at_peak(0, 128);
        watch_band(3, 5000, rises, highs, first);
        check(highs >= 2100 && highs <= 2900, "R3 triangle duty near half in band 3", highs, 2500);
        freeze_at_peak(2, 128);
        watch_band(3, 5000, rises, highs, first);
        check(highs >= 3100 && highs <= 4000, "R5 inverted-sine duty near 70 percent", highs, 3550);
    endtask

    task automatic t_opposition;
        int rises, highs;
        longint tp, ta, diff;
        freeze_at_peak(0, 128);
        watch_band(3, 1200, rises, highs, tp);
        freeze_at_peak(1, 128);
        watch_band(3, 1200, rises, highs, ta);
        diff = (((ta - tp) % SLOW_CLKS) + SLOW_CLKS) % SLOW_CLKS;
        check(diff >= SLOW_CLKS / 2 - 6 && diff <= SLOW_CLKS / 2 + 6,
              "R4 odd band shifted by half a carrier period", diff, SLOW_CLKS / 2);
    endtask

    task automatic t_defer;
        int rises, highs;
        longint first;
        freeze_at_peak(0, 128);
        mode_sel  = 3'd7;
        phase_inc = 16'd32;
        repeat (4096) @(negedge clk);
        phase_inc = 16'd0;
        repeat (8) @(negedge clk);
        watch_band(3, 5000, rises, highs, first);
        check(rises >= 4 && rises <= 6, "R9 reserved code 7 ignored", rises, 5);
        mode_sel = 3'd3;
        watch_band(3, 5000, rises, highs, first);
        check(rises >= 4 && rises <= 6, "R9 mode held until zero crossing", rises, 5);
        phase_inc = 16'd32;
        repeat (4096) @(negedge clk);
        phase_inc = 16'd0;
        repeat (8) @(negedge clk);
        watch_band(3, 5000, rises, highs, first);
        check(rises >= 9 && rises <= 11, "R9 mode applied after zero crossing", rises, 10);
    endtask

    initial begin
        checks    = 0;
        errors    = 0;
        done      = 0;
        rst_n     = 1'b0;
        mode_sel  = 3'd0;
        mod_index = 8'd0;
        phase_inc = 16'd0;
        base      = 0;

        t_reset();
        t_sweep(255, 7);
        t_sweep(128, 4);
        t_sweep(0, 0);
        t_rate(0, 128, 3, 4, 6,  "R3 R11 code 0 band 3 at slow rate");
        t_rate(3, 128, 3, 9, 11, "R6 R11 code 3 middle band at double rate");
        t_rate(3, 201, 5, 4, 6,  "R6 code 3 outer band 5 at slow rate");
        t_rate(4, 128, 3, 9, 11, "R6 R11 code 4 middle band at double rate");
        t_rate(1, 201, 5, 4, 6,  "R3 R11 code 1 band 5 at slow rate");
        t_rate(2, 128, 3, 4, 6,  "R5 R11 code 2 band 3 at slow rate");
        t_rate(5, 128, 3, 9, 11, "R5 R6 R11 code 5 middle band at double rate");
        t_shape();
        t_opposition();
        t_defer();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule